// File: doc/BRIEF.md
# Capture Drain and Bus-Stop Sequencer

This block sits between a video capture front end and the memory-write master that empties its staging FIFO. It governs how capture winds down. When software clears the processing enable, a frame already in progress keeps running and a busy flag stays high until that frame ends. Software can read the FIFO write and read pointers and wait for them to match. It then raises a stop request. The master stops issuing new transfers, waits for every outstanding transfer to complete, and raises a stop acknowledge that stays up as long as the request is held. An active-low software reset bit finally clears the capture and drain state.

The FIFO storage itself, the transfer protocol and any pixel conversion are outside the block. Each transfer is modelled as one grant (`bus_gnt` while `bus_req` is high) followed later by one completion pulse (`bus_resp`). A small register file on a simple write/read port carries the control bits. The read port is combinational.

Top module: `cap_stop_seq`

## Requirements
- R1: After `rst_n` is released, every register reads 0, including the soft-reset register at 0x00C. `bus_req` and `irq` are 0.
- R2: While bit 0 of 0x00C is 0, the processing logic is held in reset. The busy flag, both FIFO pointers and the stop acknowledge read 0, and `frame_start` and `pix_valid` have no effect.
- R3: With bit 0 of 0x200 (enable) at 1 and the soft reset released, `frame_start` sets busy (bit 2 of 0x254) at the next edge. With enable at 0, `frame_start` is ignored. Each `pix_valid` cycle while busy advances the write pointer (bits 7:0 of 0x168) by one.
- R4: Clearing the enable during a frame leaves busy set, and pixels are still accepted. Busy clears at the edge that samples `frame_end`.
- R5: When write pointer minus read pointer equals FIFO_DEPTH, `pix_valid` does not advance the write pointer.
- R6: `bus_req` is high when the pointers differ, no stop is requested and fewer than MAX_OUT transfers are outstanding. Each grant advances the read pointer (bits 23:16 of 0x168) by one.
- R7: While bit 0 of 0x174 (stop request) is 1, `bus_req` stays 0 even if the FIFO holds data.
- R8: Bit 0 of 0x178 (stop acknowledge) becomes 1 only while the stop request is held and no transfer is outstanding. It stays 1 while the request is held and clears one cycle after the request is withdrawn.
- R9: A `frame_end` that ends a busy frame sets bit 0 of 0x008. Writing 1 to that bit clears it. `irq` is that bit ANDed with bit 0 of 0x004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| frame_start | input | 1 | Start of an incoming frame |
| frame_end | input | 1 | End of the incoming frame |
| pix_valid | input | 1 | Pixel word pushed into the FIFO |
| bus_req | output | 1 | Master wants to issue a transfer |
| bus_gnt | input | 1 | Transfer accepted this cycle |
| bus_resp | input | 1 | One outstanding transfer completed |
| irq | output | 1 | Frame-end interrupt |

## Verification
The bench checks that the enable drop does not cut a frame short. A design that cleared busy at once would lose the pixels that follow and show a short write pointer. It fills the FIFO past its depth, where a missing full check would let the write pointer run over the read pointer. It saturates the outstanding-transfer limit, requests a stop with transfers still open and holds grants high during the stop. An acknowledge that came early, or a master that kept issuing, would show up as an acknowledge read with outstanding work or as a moving read pointer. It also checks the acknowledge lingers exactly one cycle after withdrawal, and that the soft reset zeroes the pointers.

// File: rtl/cap_stop_pkg.sv
package cap_stop_pkg;
   localparam int DATA_W = 32;

   localparam logic [11:0] A_SRST   = 12'h00C;
   localparam logic [11:0] A_IRQEN  = 12'h004;
   localparam logic [11:0] A_IRQST  = 12'h008;
   localparam logic [11:0] A_PTRS   = 12'h168;
   localparam logic [11:0] A_STOP   = 12'h174;
   localparam logic [11:0] A_STOPOK = 12'h178;
   localparam logic [11:0] A_RUN    = 12'h200;
   localparam logic [11:0] A_STAT   = 12'h254;

   localparam int BUSY_BIT  = 2;
   localparam int RPTR_LSB  = 16;

   typedef struct packed {
      logic run_en;
      logic release_n;
      logic irq_en;
      logic stop_req;
   } ctl_t;
endpackage

// File: rtl/cap_front.sv
module cap_front #(
   parameter int PTR_W      = 8,
   parameter int FIFO_DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             run_en,
   input  logic             frame_start,
   input  logic             frame_end,
   input  logic             pix_valid,
   input  logic [PTR_W-1:0] rptr,
   output logic [PTR_W-1:0] wptr,
   output logic             busy,
   output logic             frame_done
);
   localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(FIFO_DEPTH);

   logic [PTR_W-1:0] fill;
   logic             full;
   logic             push;

   assign fill       = wptr - rptr;
   assign full       = (fill == DEPTH_V);
   assign push       = pix_valid && busy && !full;
   assign frame_done = frame_end && busy && !soft_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         wptr <= '0;
      end else if (soft_rst) begin
         busy <= 1'b0;
         wptr <= '0;
      end else begin
         if (frame_end)
            busy <= 1'b0;
         else if (frame_start && run_en)
            busy <= 1'b1;
         if (push)
            wptr <= wptr + 1'b1;
      end
   end
endmodule

// File: rtl/bus_drain.sv
module bus_drain #(
   parameter int PTR_W   = 8,
   parameter int MAX_OUT = 4,
   parameter int OUT_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stop_req,
   input  logic [PTR_W-1:0] wptr,
   input  logic             bus_gnt,
   input  logic             bus_resp,
   output logic             bus_req,
   output logic [PTR_W-1:0] rptr,
   output logic [OUT_W-1:0] out_cnt,
   output logic             stop_ack
);
   localparam logic [OUT_W-1:0] OUT_LIM = OUT_W'(MAX_OUT);

   logic             issue;
   logic             retire;
   logic [OUT_W-1:0] out_nxt;

   assign bus_req = !soft_rst && !stop_req && (wptr != rptr) && (out_cnt < OUT_LIM);
   assign issue   = bus_req && bus_gnt;
   assign retire  = bus_resp && (out_cnt != '0);

   always_comb begin
      out_nxt = out_cnt;
      if (issue)
         out_nxt = out_nxt + 1'b1;
      if (retire)
         out_nxt = out_nxt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr     <= '0;
         out_cnt  <= '0;
         stop_ack <= 1'b0;
      end else if (soft_rst) begin
         rptr     <= '0;
         out_cnt  <= '0;
         stop_ack <= 1'b0;
      end else begin
         if (issue)
            rptr <= rptr + 1'b1;
         out_cnt  <= out_nxt;
         stop_ack <= stop_req && (out_nxt == '0) && !issue;
      end
   end
endmodule

// File: rtl/cap_csr.sv
module cap_csr
   import cap_stop_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              frame_done,
   input  logic              busy,
   input  logic [PTR_W-1:0]  wptr,
   input  logic [PTR_W-1:0]  rptr,
   input  logic              stop_ack,
   output ctl_t              ctl,
   output logic              irq
);
   logic frame_pend;
   logic unused_wbits;

   assign unused_wbits = ^wdata[DATA_W-1:1];
   assign irq          = frame_pend && ctl.irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl        <= '0;
         frame_pend <= 1'b0;
      end else begin
         if (we && addr == ADDR_W'(A_RUN))   ctl.run_en    <= wdata[0];
         if (we && addr == ADDR_W'(A_SRST))  ctl.release_n <= wdata[0];
         if (we && addr == ADDR_W'(A_IRQEN)) ctl.irq_en    <= wdata[0];
         if (we && addr == ADDR_W'(A_STOP))  ctl.stop_req  <= wdata[0];
         if (frame_done)
            frame_pend <= 1'b1;
         else if (we && addr == ADDR_W'(A_IRQST) && wdata[0])
            frame_pend <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_W'(A_RUN):    rdata[0] = ctl.run_en;
         ADDR_W'(A_SRST):   rdata[0] = ctl.release_n;
         ADDR_W'(A_IRQEN):  rdata[0] = ctl.irq_en;
         ADDR_W'(A_IRQST):  rdata[0] = frame_pend;
         ADDR_W'(A_STOP):   rdata[0] = ctl.stop_req;
         ADDR_W'(A_STOPOK): rdata[0] = stop_ack;
         ADDR_W'(A_STAT):   rdata[BUSY_BIT] = busy;
         ADDR_W'(A_PTRS): begin
            rdata[PTR_W-1:0]                 = wptr;
            rdata[RPTR_LSB +: PTR_W]         = rptr;
         end
         default:           rdata = '0;
      endcase
   end
endmodule

// File: rtl/cap_stop_seq.sv
module cap_stop_seq
   import cap_stop_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int PTR_W      = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int MAX_OUT    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              pix_valid,
   output logic              bus_req,
   input  logic              bus_gnt,
   input  logic              bus_resp,
   output logic              irq
);
   localparam int OUT_W = $clog2(MAX_OUT + 1);

   generate
      if (PTR_W < 2 || PTR_W > 8) begin : g_bad_ptr
         $error("PTR_W must be 2..8 to fit the pointer register fields");
      end
      if (FIFO_DEPTH < 1 || FIFO_DEPTH >= (1 << PTR_W)) begin : g_bad_depth
         $error("FIFO_DEPTH must be 1..2**PTR_W-1");
      end
      if (MAX_OUT < 1) begin : g_bad_out
         $error("MAX_OUT must be at least 1");
      end
      if (ADDR_W < 10) begin : g_bad_addr
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   ctl_t             ctl;
   logic             soft_rst;
   logic             busy;
   logic             frame_done;
   logic             stop_ack;
   logic [PTR_W-1:0] wptr;
   logic [PTR_W-1:0] rptr;
   logic [OUT_W-1:0] out_cnt;

   assign soft_rst = !ctl.release_n;

   cap_csr #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_csr (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .frame_done(frame_done),
      .busy(busy), .wptr(wptr), .rptr(rptr), .stop_ack(stop_ack),
      .ctl(ctl), .irq(irq));

   cap_front #(.PTR_W(PTR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_front (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run_en(ctl.run_en),
      .frame_start(frame_start), .frame_end(frame_end), .pix_valid(pix_valid),
      .rptr(rptr), .wptr(wptr), .busy(busy), .frame_done(frame_done));

   bus_drain #(.PTR_W(PTR_W), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)) u_drain (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_req(ctl.stop_req),
      .wptr(wptr), .bus_gnt(bus_gnt), .bus_resp(bus_resp), .bus_req(bus_req),
      .rptr(rptr), .out_cnt(out_cnt), .stop_ack(stop_ack));
endmodule

// File: rtl/cap_stop_chk.sv
module cap_stop_chk #(
   parameter int PTR_W      = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int OUT_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             stop_q,
   input logic             bus_req,
   input logic             stop_ack,
   input logic             busy,
   input logic             frame_end,
   input logic [PTR_W-1:0] wptr,
   input logic [PTR_W-1:0] rptr,
   input logic [OUT_W-1:0] out_cnt
);
   logic [PTR_W-1:0] fill;
   assign fill = wptr - rptr;

   AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |-> !bus_req); // R7
   AST_ACK_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack |-> (out_cnt == '0)); // R8
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_q |=> !stop_ack); // R8
   AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!busy && wptr == '0 && rptr == '0 && !stop_ack)); // R2
   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_rst |=> (wptr == $past(wptr) || wptr == PTR_W'($past(wptr) + 1'b1))); // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= PTR_W'(FIFO_DEPTH)); // R5
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !frame_end && !soft_rst) |=> busy); // R4
endmodule

bind cap_stop_seq cap_stop_chk #(.PTR_W(PTR_W), .FIFO_DEPTH(FIFO_DEPTH), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_q(ctl.stop_req),
   .bus_req(bus_req), .stop_ack(stop_ack), .busy(busy), .frame_end(frame_end),
   .wptr(wptr), .rptr(rptr), .out_cnt(out_cnt));

// File: tb/test_cap_stop_seq.sv
module test_cap_stop_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        frame_start = 1'b0;
   logic        frame_end = 1'b0;
   logic        pix_valid = 1'b0;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic        bus_resp = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cap_stop_seq i_cap_stop_seq (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
      .frame_end(frame_end), .pix_valid(pix_valid), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_resp(bus_resp), .irq(irq));

   task automatic check(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick(1);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_start(); frame_start = 1'b1; tick(1); frame_start = 1'b0; endtask
   task automatic pulse_end();   frame_end = 1'b1;   tick(1); frame_end = 1'b0;   endtask
   task automatic pixels(input int n); pix_valid = 1'b1; tick(n); pix_valid = 1'b0; endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(12'h00C, v); check("R1", "soft reset reg", int'(v), 0);
      rd(12'h200, v); check("R1", "enable reg", int'(v), 0);
      rd(12'h168, v); check("R1", "pointers", int'(v), 0);
      rd(12'h178, v); check("R1", "stop ack", int'(v), 0);
      rd(12'h254, v); check("R1", "status", int'(v), 0);
      check("R1", "bus_req", int'(bus_req), 0);
      check("R1", "irq", int'(irq), 0);
   endtask

   task automatic t_held_in_reset();
      logic [31:0] v;
      wr(12'h200, 1);
      pulse_start();
      pixels(3);
      rd(12'h254, v); check("R2", "busy held", int'(v[2]), 0);
      rd(12'h168, v); check("R2", "pointers held", int'(v), 0);
      wr(12'h200, 0);
      wr(12'h00C, 1);
   endtask

   task automatic t_capture();
      logic [31:0] v;
      pulse_start();
      pixels(2);
      rd(12'h254, v); check("R3", "busy with enable off", int'(v[2]), 0);
      rd(12'h168, v); check("R3", "wptr with enable off", int'(v[7:0]), 0);
      wr(12'h200, 1);
      pulse_start();
      rd(12'h254, v); check("R3", "busy after start", int'(v[2]), 1);
      pixels(3);
      rd(12'h168, v); check("R3", "wptr after 3 pixels", int'(v[7:0]), 3);
      check("R6", "bus_req with data", int'(bus_req), 1);
   endtask

   task automatic t_drain_on_disable();
      logic [31:0] v;
      wr(12'h200, 0);
      rd(12'h254, v); check("R4", "busy after disable", int'(v[2]), 1);
      pixels(2);
      rd(12'h168, v); check("R4", "wptr after late pixels", int'(v[7:0]), 5);
      pulse_end();
      rd(12'h254, v); check("R4", "busy after frame end", int'(v[2]), 0);
      rd(12'h008, v); check("R9", "frame end pending", int'(v[0]), 1);
      check("R9", "irq masked", int'(irq), 0);
      wr(12'h004, 1);
      check("R9", "irq unmasked", int'(irq), 1);
      wr(12'h008, 1);
      rd(12'h008, v); check("R9", "pending after w1c", int'(v[0]), 0);
      check("R9", "irq after clear", int'(irq), 0);
   endtask

   task automatic t_full();
      logic [31:0] v;
      wr(12'h200, 1);
      pulse_start();
      pixels(20);
      rd(12'h168, v); check("R5", "wptr stops at depth", int'(v[7:0]), 16);
      pulse_end();
   endtask

   task automatic t_stop();
      logic [31:0] v;
      bus_gnt = 1'b1;
      tick(6);
      bus_gnt = 1'b0;
      rd(12'h168, v); check("R6", "rptr capped by outstanding limit", int'(v[23:16]), 4);
      check("R6", "bus_req at limit", int'(bus_req), 0);
      wr(12'h174, 1);
      rd(12'h178, v); check("R8", "ack with open transfers", int'(v[0]), 0);
      bus_resp = 1'b1;
      tick(3);
      rd(12'h178, v); check("R8", "ack with one open", int'(v[0]), 0);
      tick(1);
      bus_resp = 1'b0;
      rd(12'h178, v); check("R8", "ack once drained", int'(v[0]), 1);
      check("R7", "bus_req under stop", int'(bus_req), 0);
      bus_gnt = 1'b1;
      tick(3);
      bus_gnt = 1'b0;
      rd(12'h168, v); check("R7", "rptr frozen under stop", int'(v[23:16]), 4);
      rd(12'h178, v); check("R8", "ack held", int'(v[0]), 1);
      wr(12'h174, 0);
      rd(12'h178, v); check("R8", "ack on withdraw edge", int'(v[0]), 1);
      tick(1);
      rd(12'h178, v); check("R8", "ack after withdraw", int'(v[0]), 0);
      check("R6", "bus_req resumes", int'(bus_req), 1);
   endtask

   task automatic t_soft_reset();
      logic [31:0] v;
      wr(12'h174, 1);
      tick(2);
      wr(12'h00C, 0);
      tick(1);
      rd(12'h168, v); check("R2", "pointers after soft reset", int'(v), 0);
      rd(12'h178, v); check("R2", "ack after soft reset", int'(v[0]), 0);
      rd(12'h254, v); check("R2", "busy after soft reset", int'(v[2]), 0);
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_held_in_reset();
      t_capture();
      t_drain_on_disable();
      t_full();
      t_stop();
      t_soft_reset();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule